// File: doc/BRIEF.md
# Two-Bank SDRAM Command Rule Monitor

This block is a passive observer placed beside the command pins of a two-bank SDRAM interface. On every clock it turns the chip-select, row-strobe, column-strobe and write-enable levels into a command. It keeps an open or closed state and the open row for each bank, and it runs down counters for the minimum gaps that follow a mode load, an auto-refresh and a precharge. Any command that breaks the bank-state or spacing rules sets a bit in a sticky status word. Each bit stands for one rule. The monitor drives nothing on the memory side.

The top address bit selects the bank. The bit just below it carries the "all banks" flag on a precharge and the "close afterwards" flag on a read or write. The lower bits carry the row on an activate. The monitor also counts auto-refresh commands over back-to-back windows of a configurable length in cycles, and flags any window that falls short of a configurable minimum. A pulse on `clr` empties the status word.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: With `cs_n` low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 auto-refresh and 000 mode load. `cs_n` high, and any other pattern, is not a command and triggers no rule.
- R2: A read or write addressed to a closed bank sets `viol_code[0]`.
- R3: A mode load or auto-refresh issued while either bank is open sets `viol_code[1]`.
- R4: An activate addressed to a bank that is already open sets `viol_code[5]`, and the bank keeps its row.
- R5: A precharge with `addr[ADDR_W-2]` high closes both banks. With that bit low, it closes only the bank chosen by `addr[ADDR_W-1]`.
- R6: A read or write with `addr[ADDR_W-2]` high closes its bank at the end of the cycle that lies BURST_LEN cycles after the command. From that close the bank's precharge gap applies, as in R9.
- R7: Any command issued fewer than T_MRD cycles after a mode load sets `viol_code[2]`.
- R8: Any command issued fewer than T_RC cycles after an auto-refresh sets `viol_code[3]`.
- R9: A command addressed to a bank fewer than T_RP cycles after that bank closed sets `viol_code[4]`. Precharge-all, mode load and auto-refresh address both banks. A command to the other bank is not affected.
- R10: Time is split into consecutive windows of REF_WINDOW cycles. A window that holds fewer than REF_MIN auto-refresh commands sets `viol_code[6]` within two cycles of its end.
- R11: Violation bits appear one cycle after the offending command and stay set until `clr` is pulsed. A violation arriving in the same cycle as `clr` is still recorded.
- R12: `err_flag` is high exactly when any bit of `viol_code` is set.
- R13: `open_rows[b*ROW_W +: ROW_W]` holds the row that opened bank b, and reads zero while bank b is closed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, low active |
| ras_n | input | 1 | Row strobe, low active |
| cas_n | input | 1 | Column strobe, low active |
| we_n | input | 1 | Write enable, low active |
| addr | input | ADDR_W | Address bus: bank at top bit, all/auto-close flag below it, row in the rest |
| clr | input | 1 | One-cycle pulse that empties the status word |
| err_flag | output | 1 | Sticky summary of all violations |
| viol_code | output | 7 | Sticky per-rule bits, positions as in R2 to R10 |
| open_rows | output | 2*(ADDR_W-1) | Open row per bank, zero when closed |

## Verification
The embedded properties assume that the bus carries at most one command per cycle and that `clr` is a clean registered pulse. They also assume the timing parameters are at least one and BURST_LEN is at least one, so every counter reload is a real value. The stimulus drives the pins only on falling edges and issues one command per cycle, with explicit NOP cycles for spacing. It counts each gap from the command cycle, so every spacing rule is probed on both sides of its limit. The refresh window is shortened so that one passing window and one failing window both fit in the run. In every other scenario the refresh bit is masked out.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [2:0] {
    C_NONE, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS
  } cmd_e;

  localparam int NUM_VIOL      = 7;
  localparam int V_IDLE_ACCESS = 0;
  localparam int V_BANK_BUSY   = 1;
  localparam int V_TMRD        = 2;
  localparam int V_TRC         = 3;
  localparam int V_TRP         = 4;
  localparam int V_DOUBLE_ACT  = 5;
  localparam int V_REF_SHORT   = 6;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    cmd = C_NONE;
    if (!cs_n) begin
      case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b001:  cmd = C_REF;
        3'b000:  cmd = C_MRS;
        default: cmd = C_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker
  import sdram_mon_pkg::*;
#(
  parameter int ROW_W     = 11,
  parameter int T_RP      = 3,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic             sel,
  input  logic             ap,
  input  logic [ROW_W-1:0] row_in,
  output logic             active_o,
  output logic             trp_busy_o,
  output logic [ROW_W-1:0] row_o
);
  localparam int RP_W = $clog2(T_RP + 1);
  localparam int BL_W = $clog2(BURST_LEN + 1);

  logic [RP_W-1:0] trp_cnt;
  logic [BL_W-1:0] ap_cnt;
  logic            ap_pend;
  logic            pre_hit, act_hit, rw_ap, ap_fire;

  assign pre_hit    = (cmd == C_PRE) && (ap || sel);
  assign act_hit    = (cmd == C_ACT) && sel;
  assign rw_ap      = ((cmd == C_RD) || (cmd == C_WR)) && sel && ap && active_o;
  assign ap_fire    = ap_pend && (ap_cnt == '0);
  assign trp_busy_o = (trp_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      ap_pend  <= 1'b0;
      ap_cnt   <= '0;
      trp_cnt  <= '0;
      row_o    <= '0;
    end else begin
      if (trp_cnt != '0) trp_cnt <= trp_cnt - RP_W'(1);
      if (pre_hit || ap_fire) begin
        active_o <= 1'b0;
        ap_pend  <= 1'b0;
        ap_cnt   <= '0;
        trp_cnt  <= RP_W'(T_RP - 1);
        row_o    <= '0;
      end else begin
        if (act_hit && !active_o) begin
          active_o <= 1'b1;
          row_o    <= row_in;
        end
        if (rw_ap) begin
          ap_pend <= 1'b1;
          ap_cnt  <= BL_W'(BURST_LEN - 1);
        end else if (ap_pend) begin
          ap_cnt <= ap_cnt - BL_W'(1);
        end
      end
    end
  end

  a_r5_pre_closes: assert property (@(posedge clk) disable iff (rst)
    pre_hit |=> !active_o);
  a_r4_act_opens: assert property (@(posedge clk) disable iff (rst)
    act_hit |=> active_o);
  a_r6_autoclose: assert property (@(posedge clk) disable iff (rst)
    ap_fire |=> !active_o);
  a_r13_idle_row_zero: assert property (@(posedge clk) disable iff (rst)
    !active_o |-> (row_o == '0));
endmodule

// File: rtl/sdram_refresh_window.sv
module sdram_refresh_window
  import sdram_mon_pkg::*;
#(
  parameter int REF_WINDOW = 10_666_666,
  parameter int REF_MIN    = 4096
) (
  input  logic clk,
  input  logic rst,
  input  cmd_e cmd,
  output logic short_o
);
  localparam int WIN_W = $clog2(REF_WINDOW);
  localparam int CNT_W = $clog2(REF_MIN + 1);
  localparam int SUM_W = CNT_W + 1;

  logic [WIN_W-1:0] win_cnt;
  logic [CNT_W-1:0] ref_cnt;
  logic [SUM_W-1:0] ref_sum;
  logic             last, is_ref;

  assign is_ref  = (cmd == C_REF);
  assign last    = (win_cnt == WIN_W'(REF_WINDOW - 1));
  assign ref_sum = SUM_W'(ref_cnt) + SUM_W'(is_ref);

  always_ff @(posedge clk) begin
    if (rst) begin
      win_cnt <= '0;
      ref_cnt <= '0;
      short_o <= 1'b0;
    end else begin
      short_o <= last && (ref_sum < SUM_W'(REF_MIN));
      if (last) begin
        win_cnt <= '0;
        ref_cnt <= '0;
      end else begin
        win_cnt <= win_cnt + WIN_W'(1);
        if (is_ref && (ref_cnt != CNT_W'(REF_MIN))) ref_cnt <= ref_cnt + CNT_W'(1);
      end
    end
  end

  a_r10_short_at_start: assert property (@(posedge clk) disable iff (rst)
    short_o |-> (win_cnt == '0));
  a_r10_count_reset: assert property (@(posedge clk) disable iff (rst)
    (win_cnt == '0) |-> (ref_cnt == '0));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int T_MRD      = 2,
  parameter int T_RC       = 10,
  parameter int T_RP       = 3,
  parameter int BURST_LEN  = 4,
  parameter int REF_WINDOW = 10_666_666,
  parameter int REF_MIN    = 4096
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cs_n,
  input  logic                      ras_n,
  input  logic                      cas_n,
  input  logic                      we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      clr,
  output logic                      err_flag,
  output logic [6:0]                viol_code,
  output logic [2*(ADDR_W-1)-1:0]   open_rows
);
  localparam int NUM_BANKS = 2;
  localparam int ROW_W     = ADDR_W - 1;
  localparam int BA_BIT    = ADDR_W - 1;
  localparam int AP_BIT    = ADDR_W - 2;
  localparam int MRD_W     = $clog2(T_MRD + 1);
  localparam int RC_W      = $clog2(T_RC + 1);

  cmd_e                  cmd;
  logic                  ba, ap, is_cmd, bank_cmd, all_cmd, ref_short;
  logic [NUM_BANKS-1:0]  bank_act, bank_trp;
  logic [MRD_W-1:0]      mrd_cnt;
  logic [RC_W-1:0]       rc_cnt;
  logic [NUM_VIOL-1:0]   new_v;

  assign ba = addr[BA_BIT];
  assign ap = addr[AP_BIT];

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  for (genvar gi = 0; gi < NUM_BANKS; gi++) begin : g_bank
    sdram_bank_tracker #(.ROW_W(ROW_W), .T_RP(T_RP), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd), .sel(ba == 1'(gi)), .ap(ap),
      .row_in(addr[ROW_W-1:0]), .active_o(bank_act[gi]),
      .trp_busy_o(bank_trp[gi]), .row_o(open_rows[gi*ROW_W +: ROW_W])
    );
  end

  sdram_refresh_window #(.REF_WINDOW(REF_WINDOW), .REF_MIN(REF_MIN)) u_ref (
    .clk(clk), .rst(rst), .cmd(cmd), .short_o(ref_short)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mrd_cnt <= '0;
      rc_cnt  <= '0;
    end else begin
      if (cmd == C_MRS)       mrd_cnt <= MRD_W'(T_MRD - 1);
      else if (mrd_cnt != '0) mrd_cnt <= mrd_cnt - MRD_W'(1);
      if (cmd == C_REF)       rc_cnt  <= RC_W'(T_RC - 1);
      else if (rc_cnt != '0)  rc_cnt  <= rc_cnt - RC_W'(1);
    end
  end

  assign is_cmd   = (cmd != C_NONE);
  assign bank_cmd = (cmd == C_ACT) || (cmd == C_RD) || (cmd == C_WR) ||
                    ((cmd == C_PRE) && !ap);
  assign all_cmd  = ((cmd == C_PRE) && ap) || (cmd == C_REF) || (cmd == C_MRS);

  always_comb begin
    new_v                = '0;
    new_v[V_IDLE_ACCESS] = ((cmd == C_RD) || (cmd == C_WR)) && !bank_act[ba];
    new_v[V_BANK_BUSY]   = ((cmd == C_MRS) || (cmd == C_REF)) && (|bank_act);
    new_v[V_TMRD]        = is_cmd && (mrd_cnt != '0);
    new_v[V_TRC]         = is_cmd && (rc_cnt != '0);
    new_v[V_TRP]         = (bank_cmd && bank_trp[ba]) || (all_cmd && (|bank_trp));
    new_v[V_DOUBLE_ACT]  = (cmd == C_ACT) && bank_act[ba];
    new_v[V_REF_SHORT]   = ref_short;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      viol_code <= '0;
      err_flag  <= 1'b0;
    end else begin
      viol_code <= (clr ? '0 : viol_code) | new_v;
      err_flag  <= (clr ? 1'b0 : err_flag) | (|new_v);
    end
  end

  a_r11_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((viol_code & $past(viol_code)) == $past(viol_code)));
  a_r12_err_matches: assert property (@(posedge clk) disable iff (rst)
    err_flag == (|viol_code));
  a_r2_idle_access: assert property (@(posedge clk) disable iff (rst)
    (((cmd == C_RD) || (cmd == C_WR)) && !bank_act[ba]) |=> viol_code[V_IDLE_ACCESS]);
  a_r4_double_act: assert property (@(posedge clk) disable iff (rst)
    ((cmd == C_ACT) && bank_act[ba]) |=> viol_code[V_DOUBLE_ACT]);
endmodule

// File: tb/sdram_cmd_monitor_tb.sv
module sdram_cmd_monitor_tb;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_REF = 3'b001, K_MRS = 3'b000, K_NOP = 3'b111;
  localparam logic [6:0] MASK = 7'b0111111;

  logic clk = 1'b0;
  logic rst, cs_n, ras_n, cas_n, we_n, clr;
  logic [11:0] addr;
  logic        err_flag;
  logic [6:0]  viol_code;
  logic [21:0] open_rows;
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.ADDR_W(12), .T_MRD(2), .T_RC(4), .T_RP(3), .BURST_LEN(4),
                      .REF_WINDOW(100), .REF_MIN(2)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(addr), .clr(clr), .err_flag(err_flag), .viol_code(viol_code), .open_rows(open_rows));

  task automatic drive_nop();
    cs_n = 1'b1; {ras_n, cas_n, we_n} = K_NOP; addr = '0; clr = 1'b0;
  endtask

  task automatic send(input logic [2:0] rcw, input logic b, input logic [10:0] low);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = rcw; addr = {b, low}; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); drive_nop(); end
  endtask

  task automatic do_clr();
    @(negedge clk); drive_nop(); clr = 1'b1;
    @(negedge clk); drive_nop();
  endtask

  task automatic check(input string req, input logic [6:0] exp, input bit full);
    logic [6:0] got, want;
    @(negedge clk); drive_nop();
    got  = full ? viol_code : (viol_code & MASK);
    want = full ? exp : (exp & MASK);
    n_tests++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s viol_code actual=%b expected=%b", req, got, want);
    end
  endtask

  task automatic check_err(input string req, input logic exp);
    n_tests++;
    if (err_flag !== exp) begin
      n_fail++;
      $display("FAIL %s err_flag actual=%b expected=%b", req, err_flag, exp);
    end
  endtask

  task automatic check_rows(input string req, input logic [21:0] exp);
    n_tests++;
    if (open_rows !== exp) begin
      n_fail++;
      $display("FAIL %s open_rows actual=%h expected=%h", req, open_rows, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); drive_nop(); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic close_all();
    send(K_PRE, 1'b0, 11'h400); idle(3);
  endtask

  task automatic t_reset();
    do_reset();
    n_tests++;
    if (viol_code !== 7'd0 || err_flag !== 1'b0 || open_rows !== '0) begin
      n_fail++;
      $display("FAIL R11 reset state actual=%b/%b expected=0/0", viol_code, err_flag);
    end
  endtask

  task automatic t_legal();
    send(K_ACT, 1'b0, 11'h010); idle(1);
    send(K_RD, 1'b0, 11'h000);  idle(1);
    send(K_WR, 1'b0, 11'h000);  idle(3);
    send(K_PRE, 1'b0, 11'h000); idle(3);
    send(K_ACT, 1'b1, 11'h020);
    check("R1 legal sequence", 7'd0, 1'b0);
    check_err("R12 no error on legal traffic", 1'b0);
    close_all();
  endtask

  task automatic t_r1_nocmd();
    @(negedge clk); cs_n = 1'b1; {ras_n, cas_n, we_n} = K_RD; addr = 12'h000;
    send(3'b110, 1'b0, 11'h000);
    check("R1 deselect and unlisted pattern ignored", 7'd0, 1'b0);
  endtask

  task automatic t_r2();
    send(K_RD, 1'b1, 11'h000);
    check("R2 read to closed bank", 7'b0000001, 1'b0);
    check_err("R12 error follows violation", 1'b1);
    idle(5);
    check("R11 bit stays set", 7'b0000001, 1'b0);
    do_clr();
    check("R11 clear empties status", 7'd0, 1'b0);
    check_err("R12 error cleared", 1'b0);
  endtask

  task automatic t_r4_r3();
    send(K_ACT, 1'b0, 11'h055); idle(1);
    send(K_ACT, 1'b0, 11'h066);
    check("R4 activate open bank", 7'b0100000, 1'b0);
    check_rows("R4 row kept", {11'h000, 11'h055});
    do_clr();
    send(K_REF, 1'b0, 11'h000); idle(4);
    check("R3 refresh with bank open", 7'b0000010, 1'b0);
    do_clr();
  endtask

  task automatic t_r5();
    send(K_ACT, 1'b1, 11'h011); idle(1);
    send(K_PRE, 1'b0, 11'h400); idle(3);
    send(K_RD, 1'b0, 11'h000);  idle(1);
    send(K_RD, 1'b1, 11'h000);
    check("R5 precharge-all closes both", 7'b0000001, 1'b0);
    do_clr();
    send(K_ACT, 1'b0, 11'h123); idle(1);
    send(K_ACT, 1'b1, 11'h2AB);
    check("R13 rows after activate", 7'd0, 1'b0);
    check_rows("R13 both rows", {11'h2AB, 11'h123});
    send(K_PRE, 1'b0, 11'h000); idle(3);
    send(K_RD, 1'b1, 11'h000);
    check("R5 single precharge spares other bank", 7'd0, 1'b0);
    check_rows("R13 closed bank reads zero", {11'h2AB, 11'h000});
    send(K_RD, 1'b0, 11'h000);
    check("R5 single precharge closed bank 0", 7'b0000001, 1'b0);
    do_clr();
    close_all();
  endtask

  task automatic t_r9();
    send(K_ACT, 1'b0, 11'h001); idle(1);
    send(K_PRE, 1'b0, 11'h000);
    send(K_ACT, 1'b0, 11'h001);
    check("R9 activate inside precharge gap", 7'b0010000, 1'b0);
    do_clr();
    send(K_PRE, 1'b0, 11'h000);
    send(K_ACT, 1'b1, 11'h002);
    check("R9 other bank unaffected", 7'd0, 1'b0);
    close_all();
    do_clr();
  endtask

  task automatic t_r7();
    send(K_MRS, 1'b0, 11'h000);
    send(K_ACT, 1'b0, 11'h000);
    check("R7 command inside mode-load gap", 7'b0000100, 1'b0);
    do_clr();
    close_all();
    send(K_MRS, 1'b0, 11'h000); idle(1);
    send(K_ACT, 1'b0, 11'h000);
    check("R7 command at mode-load limit", 7'd0, 1'b0);
    close_all();
  endtask

  task automatic t_r8();
    send(K_REF, 1'b0, 11'h000);
    send(K_ACT, 1'b0, 11'h000);
    check("R8 command inside refresh gap", 7'b0001000, 1'b0);
    do_clr();
    close_all();
    send(K_REF, 1'b0, 11'h000); idle(3);
    send(K_ACT, 1'b0, 11'h000);
    check("R8 command at refresh limit", 7'd0, 1'b0);
    close_all();
  endtask

  task automatic t_r6();
    do_clr();
    send(K_ACT, 1'b0, 11'h000); idle(1);
    send(K_RD, 1'b0, 11'h400);  idle(6);
    send(K_RD, 1'b0, 11'h000);
    check("R6 read auto-close then bank closed", 7'b0000001, 1'b0);
    do_clr();
    send(K_ACT, 1'b0, 11'h000); idle(1);
    send(K_WR, 1'b0, 11'h400);  idle(4);
    send(K_ACT, 1'b0, 11'h000);
    check("R6 activate inside gap after auto-close", 7'b0010000, 1'b0);
    do_clr();
    close_all();
  endtask

  task automatic t_r10();
    do_reset();
    send(K_REF, 1'b0, 11'h000); idle(5);
    send(K_REF, 1'b0, 11'h000); idle(100);
    check("R10 window with enough refreshes", 7'd0, 1'b1);
    send(K_REF, 1'b0, 11'h000); idle(100);
    check("R10 window short of refreshes", 7'b1000000, 1'b1);
    check_err("R12 error on refresh shortfall", 1'b1);
  endtask

  initial begin
    drive_nop(); rst = 1'b1;
    t_reset();
    t_legal();
    t_r1_nocmd();
    t_r2();
    t_r4_r3();
    t_r5();
    t_r9();
    t_r7();
    t_r8();
    t_r6();
    t_r10();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog run did not finish actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule